// File: doc/BRIEF.md
# Multi-mode PWM compare channel

This block is the output stage of a capture/compare timer. One shared period counter feeds a set of output-compare channels (two by default). The counter runs in one of three modes: a basic timer mode, an edge-aligned PWM mode that counts up and wraps, and a center-aligned PWM mode that counts up and then back down. Each channel compares the counter against its own 16-bit compare value. A 2-bit pin code picks what happens on its pin when a match or a boundary event occurs.

Compare values are double-buffered. A bus write lands in a shadow copy, and a read returns that shadow copy. The shadow values reach the live comparators only after software arms a commit and the counter then passes its overflow point, so a pulse is never cut short in mid-period. A halt input, gated by an enable bit, takes every pin at once to a level stored per channel. The pins stay there until software drops the enable.

Software reaches the block through a byte-wide strobe bus. A write takes effect at the clock edge where `bus_wr` is high. Read data appears on `bus_rdata` one edge after `bus_rd` is sampled high.

Top module: `pwm_cmp_unit`

## Requirements
- R1: After reset every pin output and output enable is 0, and every register reads 0. Map: address 0 is control, with bits [1:0] the mode (0 basic, 1 edge-aligned, 2 center-aligned, 3 acts as basic), bit 2 the run bit and bit 3 the halt enable. Addresses 1 and 2 are the period low and high bytes. Address 3 is the commit register, whose bit 0 reads back as the armed flag. Addresses 4+2i and 5+2i are the compare low and high bytes of channel i. Address 8+i is the configuration of channel i, with bits [1:0] the pin code and bit 2 the force level.
- R2: Pin code 0 (off) and pin code 2 (invalid) both hold the channel's output enable low and its pin low.
- R3: In edge-aligned mode with period P, the counter runs 0..P and then wraps to 0. With pin code 1, the pin is set on a match and cleared on the wrap, and the wrap wins if both fall in the same cycle. With compare C < P, the pin is high for P-C of every P+1 cycles.
- R4: In edge-aligned mode, pin code 2'b11 inverts the pin: it is cleared on a match and set on the wrap, so with C < P it is high for C+1 of every P+1 cycles.
- R5: In center-aligned mode with P > 0, the counter runs up to P and then down to 0, so one period is 2P cycles. With pin code 1, a match while counting up clears the pin and a match while counting down sets it.
- R6: In center-aligned mode, pin code 2'b11 sets the pin on an up-count match and clears it on a down-count match.
- R7: In basic mode the counter wraps as in edge-aligned mode. Pin code 1 sets the pin at the wrap and clears it on a match. Pin code 2'b11 toggles the pin on every match.
- R8: A write to a compare byte changes only the shadow value. The live compare, and hence the pin waveform, is unchanged until a commit. A read of a compare byte returns the last value written.
- R9: A write to address 3 sets the armed flag. At the next overflow, every shadow value moves into the live compare registers and the flag clears. Overflow is the wrap in basic and edge-aligned modes, and the bottom turnaround in center-aligned mode. With the run bit low there is no overflow, so the flag stays set.
- R10: While halt enable is 1, a high `halt_evt` drives every pin to its channel's force level in the same cycle. The output enables do not change.
- R11: Once triggered, the halt holds after `halt_evt` falls and ends only when halt enable is cleared; PWM then continues from the running counter. With halt enable at 0, `halt_evt` has no effect on the pins.
- R12: The force level of each channel reads back through the configuration register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered |
| halt_evt | input | 1 | Halt trigger event |
| pwm_out | output | NCH | Pin levels, one per channel |
| pwm_oe | output | NCH | Pin output enables, one per channel |

## Verification
The bench builds the block with its defaults: two channels, a byte-wide bus and therefore 16-bit compare values. It programs a period of 4 so that whole edge-aligned periods (5 cycles) and center-aligned periods (8 cycles) fit into short counting windows. Pin high-time counts over whole periods then show each mode's set and clear rule without depending on phase. Two channels with different codes and compare values run at the same time, which shows that a commit moves all shadows together and that the halt forces each pin to its own level.

// File: rtl/pwm_cmp_pkg.sv
package pwm_cmp_pkg;
  typedef enum logic [1:0] {
    MODE_BASIC  = 2'd0,
    MODE_EDGE   = 2'd1,
    MODE_CENTER = 2'd2,
    MODE_RSV    = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    PIN_OFF  = 2'd0,
    PIN_NORM = 2'd1,
    PIN_BAD  = 2'd2,
    PIN_ALT  = 2'd3
  } pin_code_e;

  localparam int ADDR_CTRL   = 0;
  localparam int ADDR_PER_LO = 1;
  localparam int ADDR_PER_HI = 2;
  localparam int ADDR_COMMIT = 3;
  localparam int ADDR_CMP0   = 4;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_cmp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  mode_e            mode,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             up,
  output logic             ovf
);
  logic center;
  assign center = (mode == MODE_CENTER);

  always_comb begin
    if (center) ovf = run && ((period == '0) || (!up && cnt == '0));
    else        ovf = run && (cnt >= period);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      up  <= 1'b1;
    end else if (run) begin
      if (center) begin
        if (period == '0) begin
          cnt <= '0;
          up  <= 1'b1;
        end else if (up) begin
          if (cnt >= period) begin
            up  <= 1'b0;
            cnt <= cnt - 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else if (cnt == '0) begin
          up  <= 1'b1;
          cnt <= {{(CNT_W-1){1'b0}}, 1'b1};
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else begin
        up  <= 1'b1;
        cnt <= (cnt >= period) ? '0 : cnt + 1'b1;
      end
    end
  end

  // R3: an edge-aligned count at or past the period wraps to zero
  p_edge_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (run && mode == MODE_EDGE && cnt >= period) |=> (cnt == '0));

  // R5: a center-aligned count never climbs past a stable nonzero period
  p_center_top_r5: assert property (@(posedge clk) disable iff (rst)
    (run && center && up && cnt == period && period != '0 && $stable(period))
      |=> (!up && cnt == period - 1'b1));
endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_cmp_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  localparam int CNT_W    = 2 * DATA_W,
  localparam int CFG_BASE = ADDR_CMP0 + 2 * NCH
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [DATA_W-1:0]           bus_wdata,
  output logic [DATA_W-1:0]           bus_rdata,
  input  logic                        ovf,
  output mode_e                       mode,
  output logic                        run,
  output logic                        halt_en,
  output logic [CNT_W-1:0]            period,
  output logic [NCH-1:0][CNT_W-1:0]   cmp_act,
  output logic [NCH-1:0][1:0]         code,
  output logic [NCH-1:0]              force_lvl
);
  logic [3:0]                 ctrl_q;
  logic [NCH-1:0][CNT_W-1:0]  cmp_shd;
  logic                       armed;
  logic                       wr_commit;
  logic [DATA_W-1:0]          rd_mux;

  assign mode      = mode_e'(ctrl_q[1:0]);
  assign run       = ctrl_q[2];
  assign halt_en   = ctrl_q[3];
  assign wr_commit = bus_wr && (int'(bus_addr) == ADDR_COMMIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      period    <= '0;
      cmp_shd   <= '0;
      code      <= '0;
      force_lvl <= '0;
    end else if (bus_wr) begin
      if (int'(bus_addr) == ADDR_CTRL)   ctrl_q <= bus_wdata[3:0];
      if (int'(bus_addr) == ADDR_PER_LO) period[DATA_W-1:0] <= bus_wdata;
      if (int'(bus_addr) == ADDR_PER_HI) period[CNT_W-1:DATA_W] <= bus_wdata;
      for (int i = 0; i < NCH; i++) begin
        if (int'(bus_addr) == ADDR_CMP0 + 2*i)     cmp_shd[i][DATA_W-1:0] <= bus_wdata;
        if (int'(bus_addr) == ADDR_CMP0 + 2*i + 1) cmp_shd[i][CNT_W-1:DATA_W] <= bus_wdata;
        if (int'(bus_addr) == CFG_BASE + i) begin
          code[i]      <= bus_wdata[1:0];
          force_lvl[i] <= bus_wdata[2];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed   <= 1'b0;
      cmp_act <= '0;
    end else begin
      if (armed && ovf) cmp_act <= cmp_shd;
      if (wr_commit)    armed <= 1'b1;
      else if (ovf)     armed <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (int'(bus_addr) == ADDR_CTRL)   rd_mux = DATA_W'(ctrl_q);
    if (int'(bus_addr) == ADDR_PER_LO) rd_mux = period[DATA_W-1:0];
    if (int'(bus_addr) == ADDR_PER_HI) rd_mux = period[CNT_W-1:DATA_W];
    if (int'(bus_addr) == ADDR_COMMIT) rd_mux = DATA_W'(armed);
    for (int i = 0; i < NCH; i++) begin
      if (int'(bus_addr) == ADDR_CMP0 + 2*i)     rd_mux = cmp_shd[i][DATA_W-1:0];
      if (int'(bus_addr) == ADDR_CMP0 + 2*i + 1) rd_mux = cmp_shd[i][CNT_W-1:DATA_W];
      if (int'(bus_addr) == CFG_BASE + i)        rd_mux = DATA_W'({force_lvl[i], code[i]});
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // R8: live compare values move only on an overflow edge
  p_live_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !ovf |=> $stable(cmp_act));

  // R9: an armed transfer clears the flag unless a new commit arrives
  p_armed_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (armed && ovf && !wr_commit) |=> !armed);

  // R9: a commit write always leaves the flag set
  p_armed_set_r9: assert property (@(posedge clk) disable iff (rst)
    wr_commit |=> armed);
endmodule

// File: rtl/pwm_pin_ch.sv
module pwm_pin_ch
  import pwm_cmp_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  mode_e mode,
  input  logic [1:0] code,
  input  logic  match,
  input  logic  ovf,
  input  logic  up,
  input  logic  hold,
  input  logic  force_lvl,
  output logic  out,
  output logic  oe
);
  logic pin_q;
  logic valid;

  assign valid = (code == PIN_NORM) || (code == PIN_ALT);
  assign oe    = valid;
  assign out   = hold ? force_lvl : pin_q;

  always_ff @(posedge clk) begin
    if (rst || !valid) begin
      pin_q <= 1'b0;
    end else if (!hold) begin
      unique case (mode)
        MODE_EDGE: begin
          if (ovf)        pin_q <= (code == PIN_ALT);
          else if (match) pin_q <= (code == PIN_NORM);
        end
        MODE_CENTER: begin
          if (match) pin_q <= (code == PIN_NORM) ? !up : up;
        end
        default: begin
          if (code == PIN_NORM) begin
            if (ovf)        pin_q <= 1'b1;
            else if (match) pin_q <= 1'b0;
          end else if (match) begin
            pin_q <= !pin_q;
          end
        end
      endcase
    end
  end

  // R2: an off or invalid code leaves the pin state low
  p_off_low_r2: assert property (@(posedge clk) disable iff (rst)
    !valid |=> !pin_q);

  // R11: while halted the underlying pin state is frozen
  p_freeze_r11: assert property (@(posedge clk) disable iff (rst)
    (hold && valid) |=> (!valid || $stable(pin_q)));
endmodule

// File: rtl/pwm_cmp_unit.sv
module pwm_cmp_unit
  import pwm_cmp_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              halt_evt,
  output logic [NCH-1:0]    pwm_out,
  output logic [NCH-1:0]    pwm_oe
);
  mode_e                     mode;
  logic                      run;
  logic                      halt_en;
  logic [CNT_W-1:0]          period;
  logic [NCH-1:0][CNT_W-1:0] cmp_act;
  logic [NCH-1:0][1:0]       code;
  logic [NCH-1:0]            force_lvl;
  logic [CNT_W-1:0]          cnt;
  logic                      up;
  logic                      ovf;
  logic                      halted_q;
  logic                      halt_act;

  pwm_regs #(.NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ovf(ovf), .mode(mode), .run(run), .halt_en(halt_en), .period(period),
    .cmp_act(cmp_act), .code(code), .force_lvl(force_lvl)
  );

  pwm_timebase #(.CNT_W(CNT_W)) tb_i (
    .clk(clk), .rst(rst), .run(run), .mode(mode), .period(period),
    .cnt(cnt), .up(up), .ovf(ovf)
  );

  assign halt_act = halt_en && (halted_q || halt_evt);

  always_ff @(posedge clk) begin
    if (rst || !halt_en) halted_q <= 1'b0;
    else if (halt_evt)   halted_q <= 1'b1;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pwm_pin_ch ch_i (
      .clk(clk), .rst(rst), .mode(mode), .code(code[g]),
      .match(run && (cnt == cmp_act[g])), .ovf(ovf), .up(up),
      .hold(halt_act), .force_lvl(force_lvl[g]),
      .out(pwm_out[g]), .oe(pwm_oe[g])
    );
  end

  // R10: a trigger with halt enabled forces all pins at once
  p_halt_force_r10: assert property (@(posedge clk) disable iff (rst)
    (halt_en && halt_evt) |-> (pwm_out == force_lvl));

  // R11: the halt persists while enable stays high
  p_halt_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (halt_en && halt_evt) |=> (!halt_en || pwm_out == force_lvl));
endmodule

// File: tb/pwm_cmp_unit_tb.sv
module pwm_cmp_unit_tb_top;
  localparam int NCH = 2;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0;
  logic bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic halt_evt = 1'b0;
  logic [NCH-1:0] pwm_out;
  logic [NCH-1:0] pwm_oe;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  int h0, h1;

  always #4 clk = ~clk;

  pwm_cmp_unit #(.NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .halt_evt(halt_evt), .pwm_out(pwm_out), .pwm_oe(pwm_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = DATA_W'(d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = ADDR_W'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    d = int'(bus_rdata);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_high(input int n, output int c0, output int c1);
    c0 = 0; c1 = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      c0 += int'(pwm_out[0]);
      c1 += int'(pwm_out[1]);
    end
  endtask

  task automatic t_reset();
    int d;
    chk(pwm_out == 2'b00, "R1 out", int'(pwm_out), 0);
    chk(pwm_oe == 2'b00, "R1 oe", int'(pwm_oe), 0);
    rd(0, d); chk(d == 0, "R1 ctrl", d, 0);
    rd(8, d); chk(d == 0, "R1 cfg0", d, 0);
  endtask

  task automatic t_regs();
    int d;
    wr(1, 4); wr(2, 0);
    rd(1, d); chk(d == 4, "R1 period lo", d, 4);
    wr(4, 1); wr(5, 0);
    rd(4, d); chk(d == 1, "R8 shadow read", d, 1);
    rd(3, d); chk(d == 0, "R9 not armed", d, 0);
    wr(3, 0);
    wr(6, 3); wr(7, 0);
    idle(10);
    rd(3, d); chk(d == 1, "R9 armed held while stopped", d, 1);
  endtask

  task automatic t_edge();
    int d;
    wr(8, 5);  // ch0 code 01, force 1
    wr(9, 3);  // ch1 code 11, force 0
    wr(0, 5);  // edge mode, run
    idle(20);
    rd(3, d); chk(d == 0, "R9 armed cleared", d, 0);
    chk(pwm_oe == 2'b11, "R2 oe valid", int'(pwm_oe), 3);
    count_high(20, h0, h1);
    chk(h0 == 12, "R3 edge normal", h0, 12);
    chk(h1 == 16, "R4 edge inverted", h1, 16);
  endtask

  task automatic t_shadow();
    int d;
    wr(4, 3);
    idle(20);
    count_high(20, h0, h1);
    chk(h0 == 12, "R8 no commit keeps waveform", h0, 12);
    rd(4, d); chk(d == 3, "R8 readback uncommitted", d, 3);
    wr(3, 0);
    idle(20);
    count_high(20, h0, h1);
    chk(h0 == 4, "R9 commit applied", h0, 4);
    chk(h1 == 16, "R9 other channel unchanged", h1, 16);
  endtask

  task automatic t_halt();
    int d;
    @(negedge clk); halt_evt = 1'b1;
    @(negedge clk); halt_evt = 1'b0;
    count_high(20, h0, h1);
    chk(h0 == 4, "R11 halt ignored when disabled", h0, 4);
    wr(0, 13);  // edge, run, halt enable
    @(negedge clk); halt_evt = 1'b1;
    #1;
    chk(pwm_out == 2'b01, "R10 immediate force", int'(pwm_out), 1);
    @(negedge clk); halt_evt = 1'b0;
    count_high(20, h0, h1);
    chk(h0 == 20 && h1 == 0, "R11 halt held", h0 * 100 + h1, 2000);
    chk(pwm_oe == 2'b11, "R10 oe kept", int'(pwm_oe), 3);
    rd(8, d); chk(d == 5, "R12 force readback", d, 5);
    wr(0, 5);
    idle(20);
    count_high(20, h0, h1);
    chk(h0 == 4 && h1 == 16, "R11 resume", h0 * 100 + h1, 416);
  endtask

  task automatic t_center();
    wr(0, 6);  // center mode, run
    wr(4, 1); wr(6, 2); wr(3, 0);
    idle(30);
    count_high(16, h0, h1);
    chk(h0 == 4, "R5 center normal", h0, 4);
    chk(h1 == 8, "R6 center inverted", h1, 8);
  endtask

  task automatic t_basic();
    wr(0, 4);  // basic mode, run
    idle(20);
    count_high(20, h0, h1);
    chk(h0 == 8, "R7 basic set/clear", h0, 8);
    chk(h1 == 10, "R7 basic toggle", h1, 10);
  endtask

  task automatic t_off();
    int d;
    wr(8, 6);  // ch0 code 10 invalid
    wr(9, 0);  // ch1 code 00 off
    idle(3);
    chk(pwm_oe == 2'b00, "R2 oe low", int'(pwm_oe), 0);
    count_high(20, h0, h1);
    chk(h0 == 0 && h1 == 0, "R2 pins low", h0 * 100 + h1, 0);
    rd(8, d); chk(d == 6, "R12 force readback invalid code", d, 6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_edge();
    t_shadow();
    t_halt();
    t_center();
    t_basic();
    t_off();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule